// File: doc/BRIEF.md
# Receiver-Detect Termination Controller

This block decides the termination and drive state of every channel of a multi-lane serial repeater. Each channel has its own receiver-detect sequencer. The sequencer is armed by a rising edge on that channel's reset bit. It then waits a fixed number of clock cycles, samples the load-sense comparator and keeps the result. A decision stage combines this result with the power-down, detect-enable, signal-detect and disable controls. From these it chooses the input termination, the output termination and whether the output driver is on. That choice is registered, so the analog controls never see a glitch.

The block sits between the configuration registers and the analog front end of each lane. The comparators, the equalizer and the emphasis settings are handled elsewhere. The channel count and the timeout length are parameters.

Top module: `rxdet_term_ctrl`

## Requirements
- R1: A detect cycle starts only on a clock edge where the channel reset bit reads 1, it read 0 at the previous edge, the channel is powered (global power-down low and channel power enable high) and detect enable is high. A reset bit that holds steady at 0 or at 1 never starts a cycle. The edge memory resets to 1, so a bit that is high from reset starts nothing.
- R2: While the channel reset bit is 0, the sequencer is held idle and its result is cleared. With detection enabled and the channel powered, the input is HIZ and the output is R2K.
- R3: A started cycle lasts TIMEOUT clock edges. At the last of these edges the load-sense input is captured into the detect result, which is 1 when a load was sensed and 0 when none was. Until that edge the channel shows input HIZ and output R2K.
- R4: The detect result reads 0 after reset, before the first completed cycle, and after an aborted cycle. A cycle is aborted when, before it completes, the reset bit falls, the channel loses power or detect enable drops.
- R5: When the global power-down is high or the channel power enable is low, both terminations are HIZ and the driver is off. This rule takes priority over every other rule.
- R6: When the channel is powered and detect enable is low, the input is R50. The output is R50 with the driver on while signal detect is high, and R2K with the driver off while it is low.
- R7: When detection is enabled and no load has been found (result 0 or no completed cycle), the input is HIZ, the output is R2K and the driver is off.
- R8: After a completed cycle that found a load, with the reset bit still high, the input is R50. The output is R50 with the driver on while signal detect is high, and R2K with the driver off otherwise (squelch).
- R9: An input-disable bit forces that channel's input to HIZ. An output-disable bit forces its output to HIZ and turns the driver off. Both apply whatever the other settings are.
- R10: Terminations are encoded as HIZ=2'b00, R50=2'b01 and R2K=2'b10. Channel i occupies bits [2i+1:2i] of each termination bus and bit i of every other vector. All outputs are registered: they reflect the inputs and sequencer state of the previous clock edge. After reset every termination is HIZ and every driver is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_all | input | 1 | Global power-down, 1 = all channels off |
| ch_pwr_en | input | N_CH | Per-channel power enable, 1 = powered |
| det_en | input | N_CH | Per-channel receiver-detect enable |
| ch_rst_n | input | N_CH | Per-channel reset bit, 0 = hold, rising edge starts detect |
| in_dis | input | N_CH | Per-channel input disable |
| out_dis | input | N_CH | Per-channel output disable |
| sig_ok | input | N_CH | Per-channel signal-detect flag |
| load_seen | input | N_CH | Per-channel sampled load-sense flag |
| in_term | output | 2*N_CH | Encoded input termination per channel |
| out_term | output | 2*N_CH | Encoded output termination per channel |
| drv_en | output | N_CH | Per-channel output driver enable |
| det_res | output | N_CH | Per-channel latched detect result |

## Verification
The assertions assume that every control input is a clean synchronous level that changes only between clock edges. They also assume the reset bit has been seen for at least two edges before a cycle can start. The bench meets these assumptions by changing inputs only at the falling clock edge, by holding reset for several cycles and by keeping the edge memory at 1 out of reset.

The random stimulus flips each channel's reset, enable and disable bits with low probability, so that many detect cycles run to completion while others are aborted. Signal detect and load sense are drawn freely, because the design may sample them at any edge.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
  typedef enum logic [1:0] {
    TERM_HIZ = 2'b00,
    TERM_R50 = 2'b01,
    TERM_R2K = 2'b10
  } term_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_WAIT = 2'b01,
    SEQ_DONE = 2'b10
  } seq_e;
endpackage

// File: rtl/rxdet_seq.sv
module rxdet_seq
  import rxdet_pkg::*;
#(
  parameter int TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic powered_i,
  input  logic det_en_i,
  input  logic ch_rst_n_i,
  input  logic load_i,
  output seq_e st_o,
  output logic res_o
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  seq_e          st_q;
  logic [CW-1:0] cnt_q;
  logic          res_q;
  logic          prev_q;
  logic          rise;
  logic          armed;

  assign rise  = ch_rst_n_i & ~prev_q;
  assign armed = powered_i & det_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      res_q  <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      prev_q <= ch_rst_n_i;
      case (st_q)
        SEQ_IDLE: begin
          if (rise && armed) begin
            st_q  <= SEQ_WAIT;
            cnt_q <= '0;
          end
        end
        SEQ_WAIT: begin
          if (!ch_rst_n_i || !armed) begin
            st_q  <= SEQ_IDLE;
            res_q <= 1'b0;
          end else if (cnt_q == LAST) begin
            st_q  <= SEQ_DONE;
            res_q <= load_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_DONE: begin
          if (!ch_rst_n_i) begin
            st_q  <= SEQ_IDLE;
            res_q <= 1'b0;
          end
        end
        default: begin
          st_q  <= SEQ_IDLE;
          res_q <= 1'b0;
        end
      endcase
    end
  end

  assign st_o  = st_q;
  assign res_o = res_q;

  AST_EDGE_START: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == SEQ_WAIT) |-> ($past(ch_rst_n_i) && !$past(ch_rst_n_i, 2))); // R1
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ch_rst_n_i |=> (st_q == SEQ_IDLE && !res_q)); // R2
  AST_RES_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $rose(res_q) |-> ($past(st_q) == SEQ_WAIT && $past(load_i))); // R3
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_WAIT && !det_en_i) |=> (st_q == SEQ_IDLE && !res_q)); // R4
endmodule

// File: rtl/rxdet_term.sv
module rxdet_term
  import rxdet_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  powered_i,
  input  logic  det_en_i,
  input  logic  ch_rst_n_i,
  input  seq_e  st_i,
  input  logic  res_i,
  input  logic  sig_i,
  input  logic  in_dis_i,
  input  logic  out_dis_i,
  output term_e in_term_o,
  output term_e out_term_o,
  output logic  drv_o
);
  term_e in_d, out_d;
  logic  drv_d;
  term_e in_q, out_q;
  logic  drv_q;
  logic  load_found;

  assign load_found = ch_rst_n_i && (st_i == SEQ_DONE) && res_i;

  always_comb begin
    if (!powered_i) begin
      in_d  = TERM_HIZ;
      out_d = TERM_HIZ;
      drv_d = 1'b0;
    end else if (!det_en_i || load_found) begin
      in_d  = TERM_R50;
      out_d = sig_i ? TERM_R50 : TERM_R2K;
      drv_d = sig_i;
    end else begin
      in_d  = TERM_HIZ;
      out_d = TERM_R2K;
      drv_d = 1'b0;
    end
    if (in_dis_i) in_d = TERM_HIZ;
    if (out_dis_i) begin
      out_d = TERM_HIZ;
      drv_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= TERM_HIZ;
      out_q <= TERM_HIZ;
      drv_q <= 1'b0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
      drv_q <= drv_d;
    end
  end

  assign in_term_o  = in_q;
  assign out_term_o = out_q;
  assign drv_o      = drv_q;

  AST_PWRDN_HIZ: assert property (@(posedge clk) disable iff (rst)
    !powered_i |=> (in_q == TERM_HIZ && out_q == TERM_HIZ && !drv_q)); // R5
  AST_IN_DIS: assert property (@(posedge clk) disable iff (rst)
    in_dis_i |=> (in_q == TERM_HIZ)); // R9
  AST_OUT_DIS: assert property (@(posedge clk) disable iff (rst)
    out_dis_i |=> (out_q == TERM_HIZ && !drv_q)); // R9
  AST_DRV_NEEDS_SIG: assert property (@(posedge clk) disable iff (rst)
    drv_q |-> ($past(sig_i) && out_q == TERM_R50)); // R8
endmodule

// File: rtl/rxdet_chan.sv
module rxdet_chan
  import rxdet_pkg::*;
#(
  parameter int TIMEOUT = 1000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  powered_i,
  input  logic  det_en_i,
  input  logic  ch_rst_n_i,
  input  logic  in_dis_i,
  input  logic  out_dis_i,
  input  logic  sig_i,
  input  logic  load_i,
  output term_e in_term_o,
  output term_e out_term_o,
  output logic  drv_o,
  output logic  res_o
);
  seq_e st;
  logic res;

  rxdet_seq #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .powered_i  (powered_i),
    .det_en_i   (det_en_i),
    .ch_rst_n_i (ch_rst_n_i),
    .load_i     (load_i),
    .st_o       (st),
    .res_o      (res)
  );

  rxdet_term u_term (
    .clk        (clk),
    .rst        (rst),
    .powered_i  (powered_i),
    .det_en_i   (det_en_i),
    .ch_rst_n_i (ch_rst_n_i),
    .st_i       (st),
    .res_i      (res),
    .sig_i      (sig_i),
    .in_dis_i   (in_dis_i),
    .out_dis_i  (out_dis_i),
    .in_term_o  (in_term_o),
    .out_term_o (out_term_o),
    .drv_o      (drv_o)
  );

  assign res_o = res;
endmodule

// File: rtl/rxdet_term_ctrl.sv
module rxdet_term_ctrl
  import rxdet_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_dn_all,
  input  logic [N_CH-1:0]   ch_pwr_en,
  input  logic [N_CH-1:0]   det_en,
  input  logic [N_CH-1:0]   ch_rst_n,
  input  logic [N_CH-1:0]   in_dis,
  input  logic [N_CH-1:0]   out_dis,
  input  logic [N_CH-1:0]   sig_ok,
  input  logic [N_CH-1:0]   load_seen,
  output logic [2*N_CH-1:0] in_term,
  output logic [2*N_CH-1:0] out_term,
  output logic [N_CH-1:0]   drv_en,
  output logic [N_CH-1:0]   det_res
);
  localparam int TW = 2;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    term_e in_t, out_t;
    logic  powered;

    assign powered = ~pwr_dn_all & ch_pwr_en[i];

    rxdet_chan #(.TIMEOUT(TIMEOUT)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .powered_i  (powered),
      .det_en_i   (det_en[i]),
      .ch_rst_n_i (ch_rst_n[i]),
      .in_dis_i   (in_dis[i]),
      .out_dis_i  (out_dis[i]),
      .sig_i      (sig_ok[i]),
      .load_i     (load_seen[i]),
      .in_term_o  (in_t),
      .out_term_o (out_t),
      .drv_o      (drv_en[i]),
      .res_o      (det_res[i])
    );

    assign in_term[TW*i +: TW]  = in_t;
    assign out_term[TW*i +: TW] = out_t;
  end
endmodule

// File: tb/rxdet_term_ctrl_tb.sv
module rxdet_term_ctrl_tb;
  localparam int N  = 8;
  localparam int TO = 5;
  localparam logic [1:0] HIZ = 2'b00, R50 = 2'b01, R2K = 2'b10;
  localparam int S_IDLE = 0, S_WAIT = 1, S_DONE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_all = 1'b0;
  logic [N-1:0] pwr_en = '1, den = '1, rstn = '1, idis = '0, odis = '0, sig = '0, load = 8'hA5;
  logic [2*N-1:0] in_term, out_term;
  logic [N-1:0] drv_en, det_res;

  always #2 clk = ~clk;

  rxdet_term_ctrl #(.N_CH(N), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst(rst), .pwr_dn_all(pd_all), .ch_pwr_en(pwr_en), .det_en(den),
    .ch_rst_n(rstn), .in_dis(idis), .out_dis(odis), .sig_ok(sig), .load_seen(load),
    .in_term(in_term), .out_term(out_term), .drv_en(drv_en), .det_res(det_res));

  int tests = 0, fails = 0;
  bit finished = 0;

  int m_st[N], m_cnt[N], m_res[N], m_prev[N];
  logic [1:0] e_in[N], e_out[N];
  int e_drv[N];
  string t_in[N], t_out[N], t_res[N];

  task automatic chk(string tag, int ch, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s ch%0d %s: got %0d expected %0d at %0t", tag, ch, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_st[i] = S_IDLE; m_cnt[i] = 0; m_res[i] = 0; m_prev[i] = 1;
      e_in[i] = HIZ; e_out[i] = HIZ; e_drv[i] = 0;
      t_in[i] = "R10"; t_out[i] = "R10"; t_res[i] = "R4";
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < N; i++) begin
      bit pw, armed, rise;
      pw = !pd_all && pwr_en[i];
      armed = pw && den[i];
      if (!pw) begin
        e_in[i] = HIZ; e_out[i] = HIZ; e_drv[i] = 0; t_in[i] = "R5"; t_out[i] = "R5";
      end else if (!den[i]) begin
        e_in[i] = R50; e_out[i] = sig[i] ? R50 : R2K; e_drv[i] = sig[i]; t_in[i] = "R6"; t_out[i] = "R6";
      end else if (!rstn[i]) begin
        e_in[i] = HIZ; e_out[i] = R2K; e_drv[i] = 0; t_in[i] = "R2"; t_out[i] = "R2";
      end else if (m_st[i] == S_DONE && m_res[i] == 1) begin
        e_in[i] = R50; e_out[i] = sig[i] ? R50 : R2K; e_drv[i] = sig[i]; t_in[i] = "R8"; t_out[i] = "R8";
      end else begin
        e_in[i] = HIZ; e_out[i] = R2K; e_drv[i] = 0;
        t_in[i] = (m_st[i] == S_WAIT) ? "R3" : "R7"; t_out[i] = t_in[i];
      end
      if (idis[i]) begin e_in[i] = HIZ; t_in[i] = "R9"; end
      if (odis[i]) begin e_out[i] = HIZ; e_drv[i] = 0; t_out[i] = "R9"; end
      rise = rstn[i] && (m_prev[i] == 0);
      m_prev[i] = rstn[i];
      case (m_st[i])
        S_IDLE: begin
          if (rise && armed) begin m_st[i] = S_WAIT; m_cnt[i] = 0; end
          t_res[i] = "R1";
        end
        S_WAIT: begin
          if (!rstn[i] || !armed) begin m_st[i] = S_IDLE; m_res[i] = 0; t_res[i] = "R4"; end
          else if (m_cnt[i] == TO - 1) begin m_st[i] = S_DONE; m_res[i] = load[i]; t_res[i] = "R3"; end
          else m_cnt[i]++;
        end
        default: begin
          if (!rstn[i]) begin m_st[i] = S_IDLE; m_res[i] = 0; t_res[i] = "R2"; end
        end
      endcase
    end
  endtask

  task automatic compare();
    for (int i = 0; i < N; i++) begin
      chk(t_in[i], i, "in_term", int'(in_term[2*i +: 2]), int'(e_in[i]));
      chk(t_out[i], i, "out_term", int'(out_term[2*i +: 2]), int'(e_out[i]));
      chk(t_out[i], i, "drv_en", int'(drv_en[i]), e_drv[i]);
      chk(t_res[i], i, "det_res", int'(det_res[i]), m_res[i]);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic rand_inputs();
    if ($urandom_range(63) == 0) pd_all = ~pd_all;
    for (int i = 0; i < N; i++) begin
      if ($urandom_range(47) == 0) pwr_en[i] = ~pwr_en[i];
      if ($urandom_range(31) == 0) den[i] = ~den[i];
      if ($urandom_range(11) == 0) rstn[i] = ~rstn[i];
      idis[i] = ($urandom_range(15) == 0);
      odis[i] = ($urandom_range(15) == 0);
      sig[i]  = $urandom_range(1);
      load[i] = $urandom_range(1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state of every output
    compare();
    // R1: reset bit held high from reset starts nothing
    tick(8);
    // R2: hold reset low
    rstn = '0; tick(3);
    // R3/R8: rising edge starts detect, then signal present
    rstn = '1; sig = '1; tick(TO + 3);
    sig = 8'h0F; tick(2);
    // R6: detection disabled on some lanes
    den = 8'h33; tick(3);
    den = '1; tick(1);
    // R4: abort mid-cycle by dropping reset and power
    rstn = '0; tick(1); rstn = '1; tick(2);
    rstn[1:0] = 2'b00; pwr_en[3] = 1'b0; den[5] = 1'b0; tick(2);
    pwr_en = '1; den = '1; rstn = '1; tick(TO + 2);
    // R9: disables override a lane that found a load
    sig = '1; idis = 8'h0F; odis = 8'hF0; tick(2);
    idis = '0; odis = '0;
    // R5: global power-down
    pd_all = 1'b1; tick(3); pd_all = 1'b0; tick(2);
    for (int c = 0; c < 4000; c++) begin
      rand_inputs();
      tick(1);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule